// File: doc/BRIEF.md
# Two-Wire Bus Ownership Monitor

This block watches the clock and data lines of a two-wire serial bus on behalf of a local master. It passes both lines through a two-stage synchronizer and looks for start and stop conditions. From these, and from a few strobes issued by the local master's controller, it keeps a four-way view of who holds the bus: not yet known, free, held by the local master, or held by some other device.

The state comes out as a 2-bit code. Control logic reads this code to decide whether a new transfer may begin. After reset the view is "unknown". It stays there until software forces it free, a stop condition is seen, or the optional inactivity timer runs out. Once the view is known, it never drops back to unknown unless the block is reset or disabled. The block runs on its own clock and never stops, whatever low-power mode the rest of the chip is in.

Top module: `i2c_bus_state_mon`

## Requirements
- R1: The state output uses these codes: 2'b00 unknown, 2'b01 idle, 2'b10 owner, 2'b11 busy.
- R2: While rst_n is low the state is 2'b00. A clock edge with en low sets the state to 2'b00.
- R3: In unknown, a one-cycle sw_wr with sw_state = 2'b01 moves the state to idle on the next edge. A write of any other code, or a write in any other state, leaves the state unchanged.
- R4: In unknown, a detected stop or a timer expiry moves the state to idle. While en stays high, the state never returns to unknown from any other state.
- R5: In idle, a detected start moves the state to busy. In busy, a detected stop or a timer expiry moves the state to idle.
- R6: In idle, addr_wr moves the state to owner, and this takes precedence over a start detected in the same cycle. addr_wr in owner keeps the state at owner. A start detected in busy keeps the state at busy.
- R7: In owner, arb_lost moves the state to busy and stop_cmd moves it to idle. If both are high in the same cycle, arb_lost takes precedence.
- R8: start_det is a one-cycle pulse for SDA falling while SCL stays high. stop_det is a one-cycle pulse for SDA rising while SCL stays high. The pulse is high during the cycle after the second rising clock edge that follows the change on the pins. The state reacts on the edge after that.
- R9: The inactivity timer runs only while en and tmo_en are high and the state is busy or unknown. It counts cycles in which both synchronized lines are high and neither has just changed, and it clears otherwise. It expires when the count equals tmo_limit. A tmo_limit of zero never expires.
- R10: If sw_wr in unknown falls in the same cycle as a detected start or stop, the bus event decides the next state: a start keeps the state unknown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| en | input | 1 | Master enable; low forces unknown |
| sw_wr | input | 1 | Software write strobe for the state field |
| sw_state | input | 2 | Value written by software |
| addr_wr | input | 1 | Local address write that issues a (repeated) start |
| stop_cmd | input | 1 | Local master issued a stop |
| arb_lost | input | 1 | Local master lost arbitration |
| tmo_en | input | 1 | Inactivity timeout enable |
| tmo_limit | input | TMO_W | Inactivity limit in clock cycles |
| state | output | 2 | Bus state code |
| start_det | output | 1 | Start condition detected (pulse) |
| stop_det | output | 1 | Stop condition detected (pulse) |

## Verification
A software force to idle and a start condition on the pins can act in the same cycle while the view is unknown, and the bus event has to win. A directed case lowers SDA with SCL high and times sw_wr to be high in exactly the cycle the start pulse is high. The check is that the state stays 2'b00 after that edge. The random phase toggles the lines and the software and local strobes independently, so both orders and the same-cycle case also occur there. Each cycle is judged against a bench model of the state transitions.

// File: rtl/i2c_bus_state_mon.sv
module i2c_bus_state_mon #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             en,
  input  logic             sw_wr,
  input  logic [1:0]       sw_state,
  input  logic             addr_wr,
  input  logic             stop_cmd,
  input  logic             arb_lost,
  input  logic             tmo_en,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic [1:0]       state,
  output logic             start_det,
  output logic             stop_det
);

  localparam logic [1:0] ST_UNK  = 2'b00;
  localparam logic [1:0] ST_IDLE = 2'b01;
  localparam logic [1:0] ST_OWN  = 2'b10;
  localparam logic [1:0] ST_BUSY = 2'b11;

  logic [1:0] scl_q, sda_q;
  logic       scl_d, sda_d;
  logic [TMO_W-1:0] cnt;
  logic [1:0] nxt;
  logic       lines_hi, line_edge, tmo_act, tmo_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 2'b11;
      sda_q <= 2'b11;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_i};
      sda_q <= {sda_q[0], sda_i};
      scl_d <= scl_q[1];
      sda_d <= sda_q[1];
    end
  end

  assign start_det = scl_q[1] & scl_d & sda_d & ~sda_q[1];
  assign stop_det  = scl_q[1] & scl_d & ~sda_d & sda_q[1];

  assign lines_hi  = scl_q[1] & sda_q[1];
  assign line_edge = (scl_q[1] ^ scl_d) | (sda_q[1] ^ sda_d);
  assign tmo_act   = en & tmo_en & ((state == ST_BUSY) | (state == ST_UNK));
  assign tmo_fire  = tmo_act & lines_hi & ~line_edge & (tmo_limit != '0) & (cnt == tmo_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!tmo_act || !lines_hi || line_edge)
      cnt <= '0;
    else if (cnt != tmo_limit)
      cnt <= cnt + 1'b1;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_UNK: begin
        if (stop_det || tmo_fire)
          nxt = ST_IDLE;
        else if (sw_wr && sw_state == ST_IDLE && !start_det)
          nxt = ST_IDLE;
      end
      ST_IDLE: begin
        if (addr_wr)        nxt = ST_OWN;
        else if (start_det) nxt = ST_BUSY;
      end
      ST_OWN: begin
        if (arb_lost)      nxt = ST_BUSY;
        else if (stop_cmd) nxt = ST_IDLE;
      end
      default: begin
        if (stop_det || tmo_fire) nxt = ST_IDLE;
      end
    endcase
    if (!en) nxt = ST_UNK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_UNK;
    else        state <= nxt;
  end

  p_disable_unknown_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> state == ST_UNK);

  p_no_return_unknown_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state != ST_UNK) |=> state != ST_UNK);

  p_busy_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state == ST_BUSY && !stop_det && !tmo_fire) |=> state == ST_BUSY);

  p_owner_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state == ST_IDLE && addr_wr) |=> state == ST_OWN);

  p_arb_lost_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state == ST_OWN && arb_lost) |=> state == ST_BUSY);

  p_event_beats_sw_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state == ST_UNK && start_det) |=> state == ST_UNK);

endmodule

// File: tb/i2c_bus_state_mon_tb.sv
`timescale 1ns/1ps
module i2c_bus_state_mon_tb;
  localparam int TMO_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_i = 1'b1, sda_i = 1'b1, en = 1'b0, sw_wr = 1'b0;
  logic [1:0] sw_state = 2'b00;
  logic addr_wr = 1'b0, stop_cmd = 1'b0, arb_lost = 1'b0, tmo_en = 1'b0;
  logic [TMO_W-1:0] tmo_limit = '0;
  logic [1:0] state;
  logic start_det, stop_det;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  i2c_bus_state_mon #(.TMO_W(TMO_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .en(en),
    .sw_wr(sw_wr), .sw_state(sw_state), .addr_wr(addr_wr), .stop_cmd(stop_cmd),
    .arb_lost(arb_lost), .tmo_en(tmo_en), .tmo_limit(tmo_limit),
    .state(state), .start_det(start_det), .stop_det(stop_det)
  );

  // Bench model built from the requirements (R8 latency, R9 timer, R1-R7, R10 transitions)
  logic m_scl1, m_scl2, m_scl3, m_sda1, m_sda2, m_sda3;
  logic [TMO_W-1:0] m_cnt;
  logic [1:0] m_state;

  function automatic logic [1:0] exp_next(logic [1:0] s, logic e, logic st, logic sp,
      logic to, logic w, logic [1:0] wv, logic aw, logic sc, logic al);
    logic [1:0] n = s;
    case (s)
      2'b00: if (sp || to) n = 2'b01; else if (w && wv == 2'b01 && !st) n = 2'b01;
      2'b01: if (aw) n = 2'b10; else if (st) n = 2'b11;
      2'b10: if (al) n = 2'b11; else if (sc) n = 2'b01;
      default: if (sp || to) n = 2'b01;
    endcase
    if (!e) n = 2'b00;
    return n;
  endfunction

  wire m_start = m_scl2 & m_scl3 & m_sda3 & ~m_sda2;
  wire m_stop  = m_scl2 & m_scl3 & ~m_sda3 & m_sda2;
  wire m_hi    = m_scl2 & m_sda2;
  wire m_edge  = (m_scl2 != m_scl3) || (m_sda2 != m_sda3);
  wire m_act   = en & tmo_en & (m_state == 2'b11 || m_state == 2'b00);
  wire m_fire  = m_act & m_hi & ~m_edge & (tmo_limit != 0) & (m_cnt == tmo_limit);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_scl1, m_scl2, m_scl3, m_sda1, m_sda2, m_sda3} <= 6'b111111;
      m_cnt <= '0;
      m_state <= 2'b00;
    end else begin
      m_scl1 <= scl_i; m_scl2 <= m_scl1; m_scl3 <= m_scl2;
      m_sda1 <= sda_i; m_sda2 <= m_sda1; m_sda3 <= m_sda2;
      if (!m_act || !m_hi || m_edge) m_cnt <= '0;
      else if (m_cnt != tmo_limit) m_cnt <= m_cnt + 1'b1;
      m_state <= exp_next(m_state, en, m_start, m_stop, m_fire, sw_wr, sw_state,
                          addr_wr, stop_cmd, arb_lost);
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 state vs model", state, m_state);
      chk("R8 start_det vs model", start_det, m_start);
      chk("R8 stop_det vs model", stop_det, m_stop);
    end
  end

  task automatic nwait(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lines(logic c, logic d);
    scl_i = c; sda_i = d;
    nwait(3);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1; nwait(1); sig = 1'b0; nwait(1);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    nwait(3);
    chk("R2 state in reset", state, 2'b00);
    rst_n = 1'b1;
    nwait(2);
    chk("R2 unknown after reset", state, 2'b00);
    chk("R8 no pulse at rest", {start_det, stop_det}, 2'b00);

    en = 1'b1; nwait(2);
    sw_state = 2'b10; pulse(sw_wr);
    chk("R3 non-idle write ignored", state, 2'b00);
    sw_state = 2'b01; pulse(sw_wr);
    chk("R3 forced idle", state, 2'b01);
    sw_state = 2'b00; pulse(sw_wr);
    chk("R3 write ignored outside unknown", state, 2'b01);

    scl_i = 1'b1; sda_i = 1'b0;
    nwait(2);
    chk("R8 start pulse after two edges", start_det, 1'b1);
    nwait(1);
    chk("R5 external start -> busy", state, 2'b11);
    lines(1'b0, 1'b0); lines(1'b0, 1'b1); lines(1'b1, 1'b1); lines(1'b1, 1'b0);
    chk("R6 repeated start keeps busy", state, 2'b11);
    sda_i = 1'b1; nwait(2);
    chk("R8 stop pulse", stop_det, 1'b1);
    nwait(1);
    chk("R5 stop -> idle", state, 2'b01);

    pulse(addr_wr);
    chk("R6 address write -> owner", state, 2'b10);
    pulse(addr_wr);
    chk("R6 repeated start keeps owner", state, 2'b10);
    pulse(stop_cmd);
    chk("R7 local stop -> idle", state, 2'b01);
    pulse(addr_wr);
    arb_lost = 1'b1; stop_cmd = 1'b1; nwait(1);
    arb_lost = 1'b0; stop_cmd = 1'b0; nwait(1);
    chk("R7 arbitration lost beats stop -> busy", state, 2'b11);

    lines(1'b0, 1'b1); lines(1'b1, 1'b1);
    tmo_limit = 16'd20; tmo_en = 1'b0;
    nwait(40);
    chk("R9 timer off keeps busy", state, 2'b11);
    tmo_en = 1'b1;
    nwait(10);
    chk("R9 busy before limit", state, 2'b11);
    nwait(20);
    chk("R9 timeout -> idle", state, 2'b01);
    tmo_en = 1'b0;

    en = 1'b0; nwait(1);
    chk("R2 disable -> unknown", state, 2'b00);
    en = 1'b1; nwait(2);
    chk("R4 stays unknown without event", state, 2'b00);
    sda_i = 1'b0; nwait(2);
    sw_state = 2'b01; sw_wr = 1'b1; nwait(1); sw_wr = 1'b0;
    chk("R10 start beats software write", state, 2'b00);
    nwait(2);
    sda_i = 1'b1; nwait(3);
    chk("R4 stop from unknown -> idle", state, 2'b01);

    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 3) == 0) scl_i = ~scl_i;
      if ($urandom_range(0, 4) == 0) sda_i = ~sda_i;
      addr_wr  = ($urandom_range(0, 30) == 0);
      stop_cmd = ($urandom_range(0, 25) == 0);
      arb_lost = ($urandom_range(0, 40) == 0);
      sw_wr    = ($urandom_range(0, 30) == 0);
      sw_state = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 300) == 0) en = 1'b0;
      else if ($urandom_range(0, 20) == 0) en = 1'b1;
      if ($urandom_range(0, 200) == 0) begin
        tmo_en = $urandom_range(0, 1) == 1;
        tmo_limit = 16'($urandom_range(0, 12));
      end
      if ($urandom_range(0, 60) == 0) begin
        scl_i = 1'b1; sda_i = 1'b1;
        nwait(14);
      end
      nwait(1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule